// File: doc/BRIEF.md
# Four-Channel DMA Sequencer

This block runs direct memory access for four peripherals. Each channel has a working memory address and a remaining-transfer count. Writing either value also saves a shadow copy of it. A small write-only configuration port loads these registers. The same port loads one control word that holds the channel enables, the priority mode, the transfer mode and the per-channel reload bits.

When an enabled channel with a nonzero count sees its request line high, the block raises a hold request to the host. It waits for hold acknowledge. It then arbitrates among the eligible channels and runs four-clock byte cycles. During each cycle it drives the channel's address, a read strobe, a write strobe, a one-hot acknowledge to the chosen peripheral and, on that channel's final byte, a terminal-count flag. In single mode the bus goes back to the host after every byte. In burst mode the block keeps the bus while the same channel still has work. With reload enabled, a channel that finishes restores its address and count from the shadow copies and stays active.

The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset two clocks after `rst_n` rises.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, `hold_req`, `dack`, `mem_rd`, `mem_wr` and `term_cnt` are all low.
- R2: A channel is eligible only when its request is high, its enable bit is set and its count is nonzero. An eligible channel raises `hold_req`. No `dack` is driven unless both `hold_req` and `hold_ack` are high.
- R3: A byte transfer lasts four clocks. `dack` is one-hot and `mem_addr` is constant for all four. `mem_rd` is high only in the second clock and `mem_wr` only in the third.
- R4: After each transfer, the channel's address rises by one and its count falls by one.
- R5: `term_cnt` is high for all four clocks of the transfer made when the count is 1. Afterwards the channel's enable bit is cleared unless its reload bit is set.
- R6: In fixed priority mode (control bit 4 = 0), the lowest-numbered eligible channel wins.
- R7: In rotating mode (control bit 4 = 1), the search starts at the channel after the one granted last, so the channel just served becomes the lowest. The pointer starts at channel 0 after reset.
- R8: A channel whose enable bit (control bits 3:0, bit n for channel n) is clear has its request ignored. With no other eligible channel, `hold_req` stays low.
- R9: In burst mode (control bit 5 = 1), the next transfer of the same channel starts on the clock after the previous one ends, with no arbitration and no drop of `hold_req`. This holds while its request stays high and it still has work.
- R10: In single mode (control bit 5 = 0), `hold_req` is low on the clock after every transfer.
- R11: With a channel's reload bit set (control bits 11:8, bit 8+n for channel n), finishing its count restores the address and count last written, and the channel stays enabled.
- R12: In burst mode, when the granted channel stops being eligible and no other is pending, the block spends one clock owning the bus without `dack`. `hold_req` is low from the clock after that.
- R13: Configuration addresses: 2n loads the address of channel n, 2n+1 loads its count (low 14 bits), and 8 loads the control word. Address and count loads also set the shadow copies. A control write in the same clock as a terminal-count enable clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| drq | input | 4 | Peripheral request lines, one per channel |
| hold_ack | input | 1 | Host grants the bus |
| hold_req | output | 1 | Bus request to the host |
| dack | output | 4 | One-hot acknowledge to the served peripheral |
| mem_addr | output | 16 | Memory address of the current byte |
| mem_rd | output | 1 | Read strobe, second clock of a transfer |
| mem_wr | output | 1 | Write strobe, third clock of a transfer |
| term_cnt | output | 1 | Final transfer of the served channel |

## Verification
Two things can land on the same clock edge: the terminal-count logic clearing a finished channel's enable bit, and a control-word write from the configuration port. The bench provokes this by issuing a control write that keeps the channel enabled, timed to the edge that ends the channel's last byte. It then loads a fresh count while the request is still high. If the write won, the channel must run another transfer. If the hardware clear had won, no transfer would start and the wait for one would time out.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITH,
    ST_OWN,
    ST_C1,
    ST_C2,
    ST_C3,
    ST_C4
  } dma_st_e;

endpackage

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic [CHW-1:0] ptr,
  output logic           gnt_valid,
  output logic [CHW-1:0] gnt_idx
);

  // Walk the candidates from last to first so the first hit in search
  // order is the one left standing.
  always_comb begin
    logic [CHW-1:0] idx;
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      idx = rotate ? CHW'(ptr + CHW'(i)) : CHW'(i);
      if (req[idx]) begin
        gnt_valid = 1'b1;
        gnt_idx   = idx;
      end
    end
  end

endmodule

// File: rtl/dma4_chan.sv
module dma4_chan #(
  parameter int AW = 16,
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] wdata,
  input  logic          step,
  input  logic          autoload,
  output logic [AW-1:0] cur_addr,
  output logic          last,
  output logic          nonzero
);

  logic [AW-1:0] addr_q, addr_n, sh_addr_q, sh_addr_n;
  logic [CW-1:0] cnt_q, cnt_n, sh_cnt_q, sh_cnt_n;
  logic          reload;
  logic          addr_en, cnt_en;

  assign last    = (cnt_q == CW'(1));
  assign nonzero = (cnt_q != '0);
  assign reload  = step && last && autoload;
  assign addr_en = ld_addr || step;
  assign cnt_en  = ld_cnt || step;

  always_comb begin
    addr_n    = addr_q;
    sh_addr_n = sh_addr_q;
    if (ld_addr) begin
      addr_n    = wdata;
      sh_addr_n = wdata;
    end else if (reload) begin
      addr_n = sh_addr_q;
    end else if (step) begin
      addr_n = addr_q + AW'(1);
    end
  end

  always_comb begin
    cnt_n    = cnt_q;
    sh_cnt_n = sh_cnt_q;
    if (ld_cnt) begin
      cnt_n    = wdata[CW-1:0];
      sh_cnt_n = wdata[CW-1:0];
    end else if (reload) begin
      cnt_n = sh_cnt_q;
    end else if (step) begin
      cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      sh_addr_q <= '0;
    end else if (addr_en) begin
      addr_q    <= addr_n;
      sh_addr_q <= sh_addr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q    <= cnt_n;
      sh_cnt_q <= sh_cnt_n;
    end
  end

  assign cur_addr = addr_q;

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           hold_ack,
  input  logic           req_any,
  input  logic           gnt_valid,
  input  logic [CHW-1:0] gnt_idx,
  input  logic           burst,
  input  logic           cont,
  output dma_st_e        st_o,
  output logic [CHW-1:0] ch_o,
  output logic [CHW-1:0] ptr_o,
  output logic           step_o
);

  dma_st_e        st_q, st_n;
  logic [CHW-1:0] ch_q, ch_n, ptr_q, ptr_n;
  logic           grant;

  assign grant = (st_q == ST_OWN) && req_any && gnt_valid;

  always_comb begin
    st_n  = st_q;
    ch_n  = ch_q;
    ptr_n = ptr_q;
    unique case (st_q)
      ST_IDLE:  if (req_any) st_n = ST_WAITH;
      ST_WAITH: if (hold_ack) st_n = ST_OWN;
      ST_OWN: begin
        if (!req_any) begin
          st_n = ST_IDLE;
        end else if (gnt_valid) begin
          st_n  = ST_C1;
          ch_n  = gnt_idx;
          ptr_n = CHW'(gnt_idx + CHW'(1));
        end
      end
      ST_C1: st_n = ST_C2;
      ST_C2: st_n = ST_C3;
      ST_C3: st_n = ST_C4;
      ST_C4: begin
        if (burst) st_n = cont ? ST_C1 : ST_OWN;
        else       st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q  <= '0;
      ptr_q <= '0;
    end else if (grant) begin
      ch_q  <= ch_n;
      ptr_q <= ptr_n;
    end
  end

  assign st_o   = st_q;
  assign ch_o   = ch_q;
  assign ptr_o  = ptr_q;
  assign step_o = (st_q == ST_C4);

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 14,
  localparam int CHW  = $clog2(NCH),
  localparam int CFGW = CHW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CFGW-1:0] cfg_addr,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic [NCH-1:0]  drq,
  input  logic            hold_ack,
  output logic            hold_req,
  output logic [NCH-1:0]  dack,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            term_cnt
);

  // Control word layout
  localparam int ROT_BIT   = NCH;
  localparam int BURST_BIT = NCH + 1;
  localparam int AUTO_LSB  = NCH + 4;
  localparam logic [CFGW-1:0] CTL_SEL = CFGW'(1) << (CFGW - 1);

  // Reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // Control register
  logic [NCH-1:0] en_q, en_n, auto_q, auto_n;
  logic           rot_q, rot_n, burst_q, burst_n;
  logic           ctl_we, ctl_en;

  // Channel bank
  logic [AW-1:0]  ch_addr [NCH];
  logic [NCH-1:0] ch_last, ch_nz, ld_addr, ld_cnt, ch_step;

  // Sequencer and arbiter
  dma_st_e        st;
  logic [CHW-1:0] cur_ch, ptr;
  logic           step, gnt_valid, req_any, cont, busy, tc_clear;
  logic [CHW-1:0] gnt_idx;
  logic [NCH-1:0] req_v;

  assign ctl_we = cfg_we && (cfg_addr == CTL_SEL);

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      assign ld_addr[gi] = cfg_we && !cfg_addr[CFGW-1] &&
                           (cfg_addr[CHW:1] == CHW'(gi)) && !cfg_addr[0];
      assign ld_cnt[gi]  = cfg_we && !cfg_addr[CFGW-1] &&
                           (cfg_addr[CHW:1] == CHW'(gi)) && cfg_addr[0];
      assign ch_step[gi] = step && (cur_ch == CHW'(gi));

      dma4_chan #(
        .AW(AW),
        .CW(CW)
      ) i_chan (
        .clk      (clk),
        .rst_ni   (rst_i),
        .ld_addr  (ld_addr[gi]),
        .ld_cnt   (ld_cnt[gi]),
        .wdata    (cfg_wdata),
        .step     (ch_step[gi]),
        .autoload (auto_q[gi]),
        .cur_addr (ch_addr[gi]),
        .last     (ch_last[gi]),
        .nonzero  (ch_nz[gi])
      );
    end
  endgenerate

  assign req_v   = drq & en_q & ch_nz;
  assign req_any = |req_v;

  dma4_arb #(
    .NCH(NCH)
  ) i_arb (
    .req       (req_v),
    .rotate    (rot_q),
    .ptr       (ptr),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  // Burst continuation: same channel keeps going if it still has work
  assign cont = drq[cur_ch] && en_q[cur_ch] &&
                (!ch_last[cur_ch] || auto_q[cur_ch]);

  dma4_seq #(
    .NCH(NCH)
  ) i_seq (
    .clk       (clk),
    .rst_ni    (rst_i),
    .hold_ack  (hold_ack),
    .req_any   (req_any),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .burst     (burst_q),
    .cont      (cont),
    .st_o      (st),
    .ch_o      (cur_ch),
    .ptr_o     (ptr),
    .step_o    (step)
  );

  // Control next state: a software write overrides the terminal-count clear
  assign tc_clear = step && ch_last[cur_ch] && !auto_q[cur_ch];
  assign ctl_en   = ctl_we || tc_clear;

  always_comb begin
    en_n    = en_q;
    auto_n  = auto_q;
    rot_n   = rot_q;
    burst_n = burst_q;
    if (tc_clear) en_n[cur_ch] = 1'b0;
    if (ctl_we) begin
      en_n    = cfg_wdata[NCH-1:0];
      rot_n   = cfg_wdata[ROT_BIT];
      burst_n = cfg_wdata[BURST_BIT];
      auto_n  = cfg_wdata[AUTO_LSB +: NCH];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q    <= '0;
      auto_q  <= '0;
      rot_q   <= 1'b0;
      burst_q <= 1'b0;
    end else if (ctl_en) begin
      en_q    <= en_n;
      auto_q  <= auto_n;
      rot_q   <= rot_n;
      burst_q <= burst_n;
    end
  end

  // Outputs
  assign busy     = (st == ST_C1) || (st == ST_C2) || (st == ST_C3) || (st == ST_C4);
  assign hold_req = (st != ST_IDLE);
  assign dack     = busy ? (NCH'(1) << cur_ch) : '0;
  assign mem_addr = busy ? ch_addr[cur_ch] : '0;
  assign mem_rd   = (st == ST_C2);
  assign mem_wr   = (st == ST_C3);
  assign term_cnt = busy && ch_last[cur_ch];

endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hrq,
  input logic           hlda,
  input logic [NCH-1:0] dack,
  input logic [AW-1:0]  mem_addr,
  input logic           rd,
  input logic           wr,
  input logic           tc
);

  // R3: one peripheral at a time
  p_dack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R2: no acknowledge without the bus
  p_dack_needs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> (hrq && hlda));

  // R3: write strobe follows read strobe with address and channel held
  p_wr_follows_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (wr && !rd && $stable(dack) && $stable(mem_addr)));

  // R3: strobes never overlap and only inside a transfer
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));

  p_strobe_in_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd || wr) |-> (dack != '0));

  // R5: terminal count only while a channel is acknowledged
  p_tc_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (dack != '0));

  // R5: terminal count is steady across the read and write clocks
  p_tc_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> $stable(tc));

endmodule

bind dma4_ctrl dma4_ctrl_chk #(
  .NCH(NCH),
  .AW (AW)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hrq      (hold_req),
  .hlda     (hold_ack),
  .dack     (dack),
  .mem_addr (mem_addr),
  .rd       (mem_rd),
  .wr       (mem_wr),
  .tc       (term_cnt)
);

// File: tb/test_dma4_ctrl.sv
`timescale 1ns/1ps
module test_dma4_ctrl;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [3:0]  drq;
  logic        hold_ack;
  logic        hold_req;
  logic [3:0]  dack;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, term_cnt;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  localparam logic [3:0] CTL = 4'd8;

  // Vector fields: {enable mask, request lines, expected channel (F = none)}
  localparam logic [11:0] VEC [8] = '{
    12'hFF0, 12'hFE1, 12'hFC2, 12'hF83,
    12'hEF1, 12'h3CF, 12'hAF1, 12'h5C2
  };

  dma4_ctrl i_dma4_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .drq      (drq),
    .hold_ack (hold_ack),
    .hold_req (hold_req),
    .dack     (dack),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .term_cnt (term_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Host model: grants the bus one clock after it is requested
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_ack <= 1'b0;
    else        hold_ack <= hold_req;
  end

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Call right after a negedge
  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Waits for a transfer, follows its four clocks, returns at the last one
  task automatic wait_xfer(output int ch, output int a, output int t,
                           output int wt, output bit shape);
    logic [3:0] d0;
    ch = -1; a = -1; t = -1; wt = 0; shape = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      wt++;
      if (dack != 4'b0) break;
    end
    if (dack == 4'b0) return;
    for (int i = 0; i < 4; i++) if (dack[i]) ch = i;
    d0 = dack; a = int'(mem_addr); t = int'(term_cnt);
    shape = $onehot(dack) && !mem_rd && !mem_wr;
    @(negedge clk);
    shape &= (dack == d0) && mem_rd && !mem_wr && (int'(mem_addr) == a) && (int'(term_cnt) == t);
    @(negedge clk);
    shape &= (dack == d0) && !mem_rd && mem_wr && (int'(mem_addr) == a) && (int'(term_cnt) == t);
    @(negedge clk);
    shape &= (dack == d0) && !mem_rd && !mem_wr && (int'(mem_addr) == a) && (int'(term_cnt) == t);
  endtask

  task automatic xfer(input int ech, input int ea, input int et, input string tag);
    int ch, a, t, wt;
    bit sh;
    wait_xfer(ch, a, t, wt, sh);
    chk(ch == ech, {tag, " channel"}, ch, ech);
    if (ea >= 0) chk(a == ea, {tag, " address"}, a, ea);
    if (et >= 0) chk(t == et, {tag, " term_cnt"}, t, et);
    chk(sh, "R3 four-clock transfer shape", int'(sh), 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int ch, a, t, wt;
    bit sh, seen;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; drq = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!hold_req && dack == 0 && !mem_rd && !mem_wr && !term_cnt, "R1 outputs in reset",
        int'({hold_req, dack, mem_rd, mem_wr, term_cnt}), 0);
    rst_n = 1'b1;
    idle(4);
    chk(!hold_req && dack == 0 && !term_cnt, "R1 outputs after reset",
        int'({hold_req, dack, term_cnt}), 0);

    // Vector walk: fixed priority (R6) and masking (R8), single mode
    for (int c = 0; c < 4; c++) begin
      cfg_write(4'(2 * c), 16'h0000);
      cfg_write(4'(2 * c + 1), 16'd100);
    end
    for (int v = 0; v < 8; v++) begin
      cfg_write(CTL, {12'h000, VEC[v][11:8]});
      drq = VEC[v][7:4];
      if (VEC[v][3:0] == 4'hF) begin
        seen = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); seen |= hold_req; end
        chk(!seen, "R8 masked requests ignored", int'(seen), 0);
        drq = 0;
      end else begin
        xfer(int'(VEC[v][3:0]), -1, -1, "R6 fixed priority");
        drq = 0;
      end
      idle(4);
    end

    // Single-mode run to terminal count: R2 R3 R4 R5 R10
    cfg_write(4'd2, 16'h1230);
    cfg_write(4'd3, 16'd3);
    cfg_write(CTL, 16'h0002);
    drq = 4'b0010;
    @(negedge clk);
    chk(hold_req && dack == 0, "R2 hold requested, no dack before grant",
        int'({hold_req, dack}), 16);
    for (int n = 0; n < 3; n++) begin
      xfer(1, 16'h1230 + n, (n == 2) ? 1 : 0, "R4 R5 counted transfer");
      @(negedge clk);
      chk(!hold_req, "R10 bus released after single transfer", int'(hold_req), 0);
    end
    seen = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); seen |= hold_req; end
    chk(!seen, "R5 channel disabled after terminal count", int'(seen), 0);
    drq = 0;
    idle(3);

    // Burst mode: R9 R12
    cfg_write(4'd4, 16'h2000);
    cfg_write(4'd5, 16'd5);
    cfg_write(CTL, 16'h0024);
    drq = 4'b0100;
    xfer(2, 16'h2000, 0, "R9 burst first");
    for (int n = 1; n < 3; n++) begin
      wait_xfer(ch, a, t, wt, sh);
      chk(wt == 1 && ch == 2, "R9 burst back-to-back", wt, 1);
      chk(a == 16'h2000 + n && sh, "R9 R4 burst address", a, 16'h2000 + n);
    end
    drq = 0;
    @(negedge clk);
    chk(hold_req && dack == 0, "R12 one owning clock after burst", int'({hold_req, dack}), 16);
    @(negedge clk);
    chk(!hold_req, "R12 bus released", int'(hold_req), 0);
    idle(3);
    drq = 4'b0100;
    xfer(2, 16'h2003, 0, "R9 burst resumed");
    wait_xfer(ch, a, t, wt, sh);
    chk(wt == 1 && a == 16'h2004 && t == 1, "R9 R5 burst ends on count", a, 16'h2004);
    @(negedge clk);
    chk(hold_req && dack == 0, "R12 owning clock at count end", int'({hold_req, dack}), 16);
    @(negedge clk);
    chk(!hold_req, "R12 release at count end", int'(hold_req), 0);
    drq = 0;
    idle(3);

    // Reload: R11
    cfg_write(4'd6, 16'h3000);
    cfg_write(4'd7, 16'd2);
    cfg_write(CTL, 16'h0808);
    drq = 4'b1000;
    xfer(3, 16'h3000, 0, "R11 reload first");
    xfer(3, 16'h3001, 1, "R11 reload final");
    xfer(3, 16'h3000, 0, "R11 reload repeats block");
    drq = 0;
    idle(6);

    // Rotating priority: R7 (pointer is at channel 0 after channel 3 was served)
    for (int c = 0; c < 3; c++) cfg_write(4'(2 * c + 1), 16'd50);
    cfg_write(CTL, 16'h0017);
    drq = 4'b0111;
    xfer(0, -1, 0, "R7 rotate step 0");
    xfer(1, -1, 0, "R7 rotate step 1");
    xfer(2, -1, 0, "R7 rotate step 2");
    xfer(0, -1, 0, "R7 rotate wraps");
    drq = 0;
    idle(6);

    // Control write on the terminal-count edge: R13
    cfg_write(4'd1, 16'd1);
    cfg_write(CTL, 16'h0001);
    drq = 4'b0001;
    xfer(0, -1, 1, "R13 last byte");
    cfg_write(CTL, 16'h0001);
    cfg_write(4'd1, 16'd1);
    wait_xfer(ch, a, t, wt, sh);
    chk(ch == 0 && sh, "R13 control write wins over clear", ch, 0);
    drq = 0;
    idle(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

endmodule